// File: doc/BRIEF.md
# Line sync pattern sequencer

This block produces a programmable per-line sync and level-insertion waveform for a high-definition video output path. Two small register tables describe the waveform. The pattern table holds seven line patterns, and each pattern is four steps. Every step pairs a duration with a pointer into the level table. The level table holds eight entries. Each entry is a signed insertion level plus the horizontal and vertical sync values that apply while that entry is in use.

Both tables are loaded over a byte-wide configuration port. A transfer begins with a start-address write that names one of the two tables. Data bytes then land at auto-incrementing addresses until a stop strobe ends the transfer. Each table keeps its own address pointer.

On a line-start trigger the sequencer takes a private copy of the selected pattern and of the level table. It then steps through the non-empty steps, counting pixel clocks for each one. While a step plays, it drives the insertion level, a luma-only flag, an insert-valid strobe and the two sync outputs. A 10-bit line counter, reloaded and counted down on triggers, is brought out as well.

Top module: `line_sync_seq`

The configuration state machine has three states:
- CFG_IDLE goes to CFG_PAT on a start-address write with `cfg_tbl`=0.
- CFG_IDLE goes to CFG_LVL on a start-address write with `cfg_tbl`=1.
- Any state goes to CFG_PAT or CFG_LVL on a new start-address write.
- Any state returns to CFG_IDLE on `cfg_stop`.

The playback state machine has two states:
- ENG_IDLE goes to ENG_PLAY on a trigger whose pattern holds at least one non-empty step.
- ENG_PLAY advances to the next non-empty step when the step counter reaches zero.
- ENG_PLAY goes to ENG_IDLE when no non-empty step remains.
- Any state restarts on a new trigger. A trigger with nothing to play leads to ENG_IDLE.

## Requirements
- R1: After reset all outputs are zero, and both tables read as all-zero.
- R2: Pattern step p of entry e occupies byte addresses 8e+2p and 8e+2p+1 of the pattern table. The even byte holds duration bits [7:0]. The odd byte holds the 4-bit level pointer in bits [7:4] and duration bits [9:8] in bits [1:0].
- R3: A step with duration D > 0 keeps `ins_valid` high with that step's outputs for exactly D+1 clock cycles. The first such cycle follows the clock edge that samples `line_start`.
- R4: A step with D = 0 is skipped and takes no cycles. A pattern whose four durations are all zero produces no insertion.
- R5: The pointer bit 3 drives `ins_luma_only`, and pointer bits [2:0] select the level entry driven on `ins_level`. While `ins_valid` is low, `ins_level` and `ins_luma_only` are zero.
- R6: Level entry k occupies byte addresses 2k and 2k+1 of the level table. The even byte is the signed level. In the odd byte, bit 1 is the vertical sync value and bit 0 is the horizontal sync value.
- R7: A start-address write (`cfg_addr_wr`, table chosen by `cfg_tbl`, address on `cfg_wdata`) sets that table's pointer. Each following `cfg_data_wr` stores a byte and advances the pointer by one, until `cfg_stop`.
- R8: Data bytes addressed at or beyond the end of a table (56 pattern bytes, 16 level bytes) are dropped with no wrap-around. Data bytes after `cfg_stop` are dropped.
- R9: `hsync_o` and `vsync_o` carry the current level entry's sync bits while a step plays, and are low otherwise.
- R10: Steps play in ascending order 0 to 3. After the last non-empty step the outputs return to idle until the next trigger.
- R11: A trigger with `line_sel` of 7 or more produces no insertion.
- R12: Table writes made while a line plays do not change that line; they take effect from the next trigger.
- R13: On each trigger `line_cnt` loads `lcnt_init` if it is zero, otherwise it decrements by one. Without a trigger it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tbl | input | 1 | Table chosen by a start-address write: 0 pattern, 1 level |
| cfg_addr_wr | input | 1 | Start-address write strobe |
| cfg_data_wr | input | 1 | Data byte write strobe |
| cfg_stop | input | 1 | Ends the current transfer |
| cfg_wdata | input | 8 | Start address or data byte |
| line_start | input | 1 | Line-start trigger |
| line_sel | input | 3 | Pattern entry to play, sampled with the trigger |
| lcnt_init | input | 10 | Reload value of the line counter |
| ins_valid | output | 1 | A step is being inserted |
| ins_level | output | 8 | Signed insertion level |
| ins_luma_only | output | 1 | Insert into the luma/green channel only |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| line_cnt | output | 10 | Backward line counter |

## Verification
A wrong step index or a stale snapshot shows up as a wrong level, flag or sync value in the very cycle the faulty step plays. A miscounted duration moves the fall of `ins_valid` by one cycle or more, and this is visible at the end of each step. A pointer that wraps or keeps writing after a stop corrupts a table entry silently, so it becomes visible only on the next line that plays that entry. The bench therefore replays patterns after every boundary write. Line counter faults show one cycle after the trigger that causes them.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int DUR_W = 10;
    localparam int PTR_W = 4;
    localparam int LVL_W = 8;

    typedef struct packed {
        logic [DUR_W-1:0] dur;
        logic [PTR_W-1:0] ptr;
    } pair_t;

    typedef struct packed {
        logic signed [LVL_W-1:0] lvl;
        logic                    vs;
        logic                    hs;
    } level_t;

    typedef enum logic [1:0] {
        CFG_IDLE,
        CFG_PAT,
        CFG_LVL
    } cfg_state_e;

    typedef enum logic {
        ENG_IDLE,
        ENG_PLAY
    } eng_state_e;

endpackage

// File: rtl/lsq_cfg_port.sv
module lsq_cfg_port
    import lsq_pkg::*;
#(
    parameter int PAT_BYTES = 56,
    parameter int LVL_BYTES = 16,
    parameter int PA_W      = $clog2(PAT_BYTES),
    parameter int LA_W      = $clog2(LVL_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_tbl,
    input  logic            cfg_addr_wr,
    input  logic            cfg_data_wr,
    input  logic            cfg_stop,
    input  logic [7:0]      cfg_wdata,
    output logic            pat_we,
    output logic [PA_W-1:0] pat_waddr,
    output logic            lvl_we,
    output logic [LA_W-1:0] lvl_waddr
);

    cfg_state_e state, nxt_state;
    logic [7:0] pat_ptr, nxt_pat_ptr;
    logic [7:0] lvl_ptr, nxt_lvl_ptr;
    logic       pat_room, lvl_room;

    // A pointer stops one past the last byte: no wrap-around.
    assign pat_room = pat_ptr < 8'(PAT_BYTES);
    assign lvl_room = lvl_ptr < 8'(LVL_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CFG_IDLE;
            pat_ptr <= '0;
            lvl_ptr <= '0;
        end else begin
            state   <= nxt_state;
            pat_ptr <= nxt_pat_ptr;
            lvl_ptr <= nxt_lvl_ptr;
        end
    end

    always_comb begin
        nxt_state   = state;
        nxt_pat_ptr = pat_ptr;
        nxt_lvl_ptr = lvl_ptr;
        if (cfg_addr_wr) begin
            if (cfg_tbl) begin
                nxt_state   = CFG_LVL;
                nxt_lvl_ptr = cfg_wdata;
            end else begin
                nxt_state   = CFG_PAT;
                nxt_pat_ptr = cfg_wdata;
            end
        end else if (cfg_stop) begin
            nxt_state = CFG_IDLE;
        end else if (cfg_data_wr) begin
            unique case (state)
                CFG_IDLE: ;
                CFG_PAT:  if (pat_room) nxt_pat_ptr = pat_ptr + 8'd1;
                CFG_LVL:  if (lvl_room) nxt_lvl_ptr = lvl_ptr + 8'd1;
                default:  nxt_state = CFG_IDLE;
            endcase
        end
    end

    always_comb begin
        pat_we    = 1'b0;
        lvl_we    = 1'b0;
        pat_waddr = pat_ptr[PA_W-1:0];
        lvl_waddr = lvl_ptr[LA_W-1:0];
        if (cfg_data_wr && !cfg_addr_wr && !cfg_stop) begin
            pat_we = (state == CFG_PAT) && pat_room;
            lvl_we = (state == CFG_LVL) && lvl_room;
        end
    end

endmodule

// File: rtl/lsq_tables.sv
module lsq_tables
    import lsq_pkg::*;
#(
    parameter int ENTRIES = 7,
    parameter int PAIRS   = 4,
    parameter int LEVELS  = 8,
    parameter int PA_W    = 6,
    parameter int LA_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pat_we,
    input  logic [PA_W-1:0]                pat_waddr,
    input  logic                           lvl_we,
    input  logic [LA_W-1:0]                lvl_waddr,
    input  logic [7:0]                     wdata,
    output pair_t  [ENTRIES*PAIRS-1:0]     pat_tbl,
    output level_t [LEVELS-1:0]            lvl_tbl
);

    localparam int PI_W = PA_W - 1;
    localparam int LI_W = LA_W - 1;

    generate
        for (genvar g = 0; g < ENTRIES*PAIRS; g++) begin : g_pair
            pair_t q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (pat_we && pat_waddr[PA_W-1:1] == PI_W'(g)) begin
                    if (!pat_waddr[0]) begin
                        q.dur[7:0] <= wdata;
                    end else begin
                        q.ptr            <= wdata[7:4];
                        q.dur[DUR_W-1:8] <= wdata[DUR_W-9:0];
                    end
                end
            end
            assign pat_tbl[g] = q;
        end

        for (genvar k = 0; k < LEVELS; k++) begin : g_level
            level_t q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (lvl_we && lvl_waddr[LA_W-1:1] == LI_W'(k)) begin
                    if (!lvl_waddr[0]) begin
                        q.lvl <= wdata;
                    end else begin
                        q.vs <= wdata[1];
                        q.hs <= wdata[0];
                    end
                end
            end
            assign lvl_tbl[k] = q;
        end
    endgenerate

endmodule

// File: rtl/lsq_engine.sv
module lsq_engine
    import lsq_pkg::*;
#(
    parameter int ENTRIES = 7,
    parameter int PAIRS   = 4,
    parameter int LEVELS  = 8,
    parameter int SEL_W   = 3,
    parameter int LCNT_W  = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       line_start,
    input  logic [SEL_W-1:0]           line_sel,
    input  logic [LCNT_W-1:0]          lcnt_init,
    input  pair_t  [ENTRIES*PAIRS-1:0] pat_tbl,
    input  level_t [LEVELS-1:0]        lvl_tbl,
    output logic                       ins_valid,
    output logic signed [LVL_W-1:0]    ins_level,
    output logic                       ins_luma_only,
    output logic                       hsync_o,
    output logic                       vsync_o,
    output logic [LCNT_W-1:0]          line_cnt
);

    localparam int PIDX_W = $clog2(PAIRS);
    localparam int SK_W   = PIDX_W + 1;
    localparam int LIDX_W = $clog2(LEVELS);

    eng_state_e               state, nxt_state;
    logic [PIDX_W-1:0]        pidx, nxt_pidx;
    logic [DUR_W-1:0]         dcnt, nxt_dcnt;
    pair_t  [PAIRS-1:0]       sh_pairs, nxt_sh_pairs;
    level_t [LEVELS-1:0]      sh_lvls, nxt_sh_lvls;
    pair_t  [PAIRS-1:0]       sel_pairs;
    logic [SK_W-1:0]          first_hit, next_hit;

    // Lowest-numbered non-empty step at or after 'from'; MSB flags a hit.
    function automatic logic [SK_W-1:0] seek_step(input pair_t [PAIRS-1:0] pr,
                                                  input logic [SK_W-1:0] from);
        logic [SK_W-1:0] res;
        res = '0;
        for (int i = PAIRS-1; i >= 0; i--) begin
            if (SK_W'(i) >= from && pr[i].dur != '0) begin
                res = {1'b1, PIDX_W'(i)};
            end
        end
        return res;
    endfunction

    always_comb begin
        sel_pairs = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (line_sel == SEL_W'(e)) begin
                sel_pairs = pat_tbl[e*PAIRS +: PAIRS];
            end
        end
    end

    assign first_hit = seek_step(sel_pairs, '0);
    assign next_hit  = seek_step(sh_pairs, {1'b0, pidx} + 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            pidx     <= '0;
            dcnt     <= '0;
            sh_pairs <= '0;
            sh_lvls  <= '0;
        end else begin
            state    <= nxt_state;
            pidx     <= nxt_pidx;
            dcnt     <= nxt_dcnt;
            sh_pairs <= nxt_sh_pairs;
            sh_lvls  <= nxt_sh_lvls;
        end
    end

    always_comb begin
        nxt_state    = state;
        nxt_pidx     = pidx;
        nxt_dcnt     = dcnt;
        nxt_sh_pairs = sh_pairs;
        nxt_sh_lvls  = sh_lvls;
        if (line_start) begin
            nxt_sh_pairs = sel_pairs;
            nxt_sh_lvls  = lvl_tbl;
            if (first_hit[PIDX_W]) begin
                nxt_state = ENG_PLAY;
                nxt_pidx  = first_hit[PIDX_W-1:0];
                nxt_dcnt  = sel_pairs[first_hit[PIDX_W-1:0]].dur;
            end else begin
                nxt_state = ENG_IDLE;
            end
        end else begin
            unique case (state)
                ENG_IDLE: ;
                ENG_PLAY: begin
                    if (dcnt != '0) begin
                        nxt_dcnt = dcnt - 1'b1;
                    end else if (next_hit[PIDX_W]) begin
                        nxt_pidx = next_hit[PIDX_W-1:0];
                        nxt_dcnt = sh_pairs[next_hit[PIDX_W-1:0]].dur;
                    end else begin
                        nxt_state = ENG_IDLE;
                    end
                end
                default: nxt_state = ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        pair_t  cur;
        level_t lv;
        cur           = sh_pairs[pidx];
        lv            = sh_lvls[cur.ptr[LIDX_W-1:0]];
        ins_valid     = 1'b0;
        ins_level     = '0;
        ins_luma_only = 1'b0;
        hsync_o       = 1'b0;
        vsync_o       = 1'b0;
        if (state == ENG_PLAY) begin
            ins_valid     = 1'b1;
            ins_level     = lv.lvl;
            ins_luma_only = cur.ptr[PTR_W-1];
            hsync_o       = lv.hs;
            vsync_o       = lv.vs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (line_start) begin
            line_cnt <= (line_cnt == '0) ? lcnt_init : line_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/line_sync_seq.sv
module line_sync_seq
    import lsq_pkg::*;
#(
    parameter int ENTRIES = 7,
    parameter int PAIRS   = 4,
    parameter int LEVELS  = 8,
    parameter int SEL_W   = 3,
    parameter int LCNT_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_tbl,
    input  logic                    cfg_addr_wr,
    input  logic                    cfg_data_wr,
    input  logic                    cfg_stop,
    input  logic [7:0]              cfg_wdata,
    input  logic                    line_start,
    input  logic [SEL_W-1:0]        line_sel,
    input  logic [LCNT_W-1:0]       lcnt_init,
    output logic                    ins_valid,
    output logic signed [7:0]       ins_level,
    output logic                    ins_luma_only,
    output logic                    hsync_o,
    output logic                    vsync_o,
    output logic [LCNT_W-1:0]       line_cnt
);

    localparam int PAT_BYTES = ENTRIES * PAIRS * 2;
    localparam int LVL_BYTES = LEVELS * 2;
    localparam int PA_W      = $clog2(PAT_BYTES);
    localparam int LA_W      = $clog2(LVL_BYTES);

    logic                     pat_we, lvl_we;
    logic [PA_W-1:0]          pat_waddr;
    logic [LA_W-1:0]          lvl_waddr;
    pair_t  [ENTRIES*PAIRS-1:0] pat_tbl;
    level_t [LEVELS-1:0]      lvl_tbl;

    lsq_cfg_port #(
        .PAT_BYTES(PAT_BYTES), .LVL_BYTES(LVL_BYTES), .PA_W(PA_W), .LA_W(LA_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_tbl(cfg_tbl), .cfg_addr_wr(cfg_addr_wr),
        .cfg_data_wr(cfg_data_wr), .cfg_stop(cfg_stop), .cfg_wdata(cfg_wdata),
        .pat_we(pat_we), .pat_waddr(pat_waddr), .lvl_we(lvl_we), .lvl_waddr(lvl_waddr)
    );

    lsq_tables #(
        .ENTRIES(ENTRIES), .PAIRS(PAIRS), .LEVELS(LEVELS), .PA_W(PA_W), .LA_W(LA_W)
    ) tbl_i (
        .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_waddr(pat_waddr),
        .lvl_we(lvl_we), .lvl_waddr(lvl_waddr), .wdata(cfg_wdata),
        .pat_tbl(pat_tbl), .lvl_tbl(lvl_tbl)
    );

    lsq_engine #(
        .ENTRIES(ENTRIES), .PAIRS(PAIRS), .LEVELS(LEVELS), .SEL_W(SEL_W), .LCNT_W(LCNT_W)
    ) eng_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_sel(line_sel),
        .lcnt_init(lcnt_init), .pat_tbl(pat_tbl), .lvl_tbl(lvl_tbl),
        .ins_valid(ins_valid), .ins_level(ins_level), .ins_luma_only(ins_luma_only),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .line_cnt(line_cnt)
    );

endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
    parameter int ENTRIES = 7,
    parameter int SEL_W   = 3,
    parameter int LCNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic [SEL_W-1:0]  line_sel,
    input logic [LCNT_W-1:0] lcnt_init,
    input logic              ins_valid,
    input logic [7:0]        ins_level,
    input logic              ins_luma_only,
    input logic              hsync_o,
    input logic              vsync_o,
    input logic [LCNT_W-1:0] line_cnt
);

    assert_sync_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> (!hsync_o && !vsync_o));

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> (!ins_luma_only && ins_level == 8'd0));

    assert_bad_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_sel >= SEL_W'(ENTRIES)) |=> !ins_valid);

    assert_start_on_trigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_valid) |-> $past(line_start));

    assert_cnt_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(line_cnt));

    assert_cnt_down_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_cnt != '0) |=> (line_cnt == $past(line_cnt) - 1'b1));

    assert_cnt_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_cnt == '0) |=> (line_cnt == $past(lcnt_init)));

endmodule

bind line_sync_seq lsq_checker #(
    .ENTRIES(ENTRIES), .SEL_W(SEL_W), .LCNT_W(LCNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_sel(line_sel),
    .lcnt_init(lcnt_init), .ins_valid(ins_valid), .ins_level(ins_level),
    .ins_luma_only(ins_luma_only), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .line_cnt(line_cnt)
);

// File: tb/line_sync_seq_tb.sv
module line_sync_seq_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_tbl = 1'b0;
    logic              cfg_addr_wr = 1'b0;
    logic              cfg_data_wr = 1'b0;
    logic              cfg_stop = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic              line_start = 1'b0;
    logic [2:0]        line_sel = '0;
    logic [9:0]        lcnt_init = '0;
    logic              ins_valid;
    logic signed [7:0] ins_level;
    logic              ins_luma_only;
    logic              hsync_o;
    logic              vsync_o;
    logic [9:0]        line_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int vtotal = 0;

    int pd [7][4];
    int pp [7][4];
    int lv [8];
    int lhs [8];
    int lvs [8];

    always #5 clk = ~clk;

    line_sync_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_tbl(cfg_tbl), .cfg_addr_wr(cfg_addr_wr),
        .cfg_data_wr(cfg_data_wr), .cfg_stop(cfg_stop), .cfg_wdata(cfg_wdata),
        .line_start(line_start), .line_sel(line_sel), .lcnt_init(lcnt_init),
        .ins_valid(ins_valid), .ins_level(ins_level), .ins_luma_only(ins_luma_only),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .line_cnt(line_cnt)
    );

    always @(negedge clk) if (ins_valid) vtotal = vtotal + 1;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cfg_addr(input bit tbl, input int a);
        @(negedge clk);
        cfg_tbl = tbl; cfg_addr_wr = 1'b1; cfg_wdata = 8'(a);
        @(negedge clk);
        cfg_addr_wr = 1'b0;
    endtask

    task automatic cfg_byte(input int b);
        cfg_data_wr = 1'b1; cfg_wdata = 8'(b);
        @(negedge clk);
        cfg_data_wr = 1'b0;
    endtask

    task automatic cfg_end();
        cfg_stop = 1'b1;
        @(negedge clk);
        cfg_stop = 1'b0;
    endtask

    // R2 layout: even byte duration[7:0], odd byte {ptr, 2'b00, duration[9:8]}
    task automatic put_pair(input int e, input int p, input int d, input int ptr);
        cfg_addr(1'b0, e*8 + p*2);
        cfg_byte(d & 255);
        cfg_byte(((ptr & 15) << 4) | ((d >> 8) & 3));
        cfg_end();
        pd[e][p] = d; pp[e][p] = ptr;
    endtask

    task automatic trigger(input int sel);
        @(negedge clk);
        line_start = 1'b1; line_sel = 3'(sel);
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic cmp_out(input string tag, input int v, input int l, input int y,
                           input int h, input int s);
        chk({tag, " valid"}, int'(ins_valid), v);
        chk({tag, " level"}, int'(ins_level), l);
        chk({tag, " luma"}, int'(ins_luma_only), y);
        chk({tag, " hsync"}, int'(hsync_o), h);
        chk({tag, " vsync"}, int'(vsync_o), s);
    endtask

    // Plays an entry and compares every cycle with the bench's own table copy.
    task automatic play_check(input int sel, input string tag);
        trigger(sel);
        if (sel < 7) begin
            for (int p = 0; p < 4; p++) begin
                if (pd[sel][p] != 0) begin
                    for (int c = 0; c <= pd[sel][p]; c++) begin
                        int k;
                        k = pp[sel][p] & 7;
                        cmp_out(tag, 1, lv[k], (pp[sel][p] >> 3) & 1, lhs[k], lvs[k]);
                        @(negedge clk);
                    end
                end
            end
        end
        for (int c = 0; c < 3; c++) begin
            cmp_out({tag, " idle"}, 0, 0, 0, 0, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        cmp_out("R1 reset", 0, 0, 0, 0, 0);
        chk("R1 reset line_cnt", int'(line_cnt), 0);
        play_check(5, "R1 empty table");
    endtask

    task automatic t_levels();
        int vals [8] = '{-40, 10, 127, -128, 0, 55, -1, 90};
        cfg_addr(1'b1, 0);
        for (int k = 0; k < 8; k++) begin
            lv[k] = vals[k]; lhs[k] = k & 1; lvs[k] = (k >> 1) & 1;
            cfg_byte(vals[k] & 255);
            cfg_byte((lvs[k] << 1) | lhs[k]);
        end
        cfg_end();
    endtask

    task automatic t_basic();
        t_levels();
        put_pair(0, 0, 3, 0);
        put_pair(0, 1, 1, 10);
        put_pair(0, 2, 5, 2);
        put_pair(0, 3, 2, 11);
        play_check(0, "R2 R3 R5 R6 R7 R9 R10 basic");
        put_pair(4, 0, 300, 5);
        put_pair(4, 3, 1, 14);
        play_check(4, "R2 R3 long duration");
    endtask

    task automatic t_skip();
        put_pair(2, 0, 0, 7);
        put_pair(2, 1, 4, 4);
        put_pair(2, 2, 0, 3);
        play_check(2, "R4 skip zero steps");
        play_check(3, "R4 all zero entry");
    endtask

    task automatic t_select();
        play_check(7, "R11 select 7");
    endtask

    task automatic t_bounds();
        cfg_addr(1'b0, 54);
        cfg_byte(2); cfg_byte(8'h70); cfg_byte(8'h05); cfg_byte(8'h15);
        cfg_end();
        pd[6][3] = 2; pp[6][3] = 7;
        cfg_addr(1'b0, 60);
        cfg_byte(8'hff); cfg_byte(8'hff);
        cfg_end();
        cfg_byte(8'hff);
        cfg_addr(1'b1, 14);
        cfg_byte(8'h11); cfg_byte(8'h03); cfg_byte(8'h44); cfg_byte(8'h44);
        cfg_end();
        lv[7] = 17; lhs[7] = 1; lvs[7] = 1;
        play_check(6, "R8 R10 last step of last entry");
        play_check(0, "R8 no wrap into entry 0 or level 0");
    endtask

    task automatic t_live_write();
        int v0;
        put_pair(1, 0, 20, 6);
        v0 = vtotal;
        trigger(1);
        put_pair(1, 1, 3, 1);
        repeat (40) @(negedge clk);
        chk("R12 line unchanged by mid-line write", vtotal - v0, 21);
        play_check(1, "R12 write seen at next trigger");
    endtask

    task automatic t_linecnt();
        lcnt_init = 10'd2;
        trigger(7);
        chk("R13 load", int'(line_cnt), 2);
        lcnt_init = 10'd9;
        trigger(7);
        chk("R13 down 1", int'(line_cnt), 1);
        repeat (4) @(negedge clk);
        chk("R13 hold", int'(line_cnt), 1);
        trigger(7);
        chk("R13 down 0", int'(line_cnt), 0);
        trigger(7);
        chk("R13 reload", int'(line_cnt), 9);
    endtask

    initial begin
        for (int e = 0; e < 7; e++) for (int p = 0; p < 4; p++) begin pd[e][p] = 0; pp[e][p] = 0; end
        for (int k = 0; k < 8; k++) begin lv[k] = 0; lhs[k] = 0; lvs[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_skip();
        t_select();
        t_bounds();
        t_live_write();
        t_linecnt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule